// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the register file that sits between a host processor and the rest of an AT-style keyboard controller. The host reaches it through two byte-wide I/O locations. The data location (0x60) carries data bytes both ways. The command location (0x64) takes command bytes when written and returns the status byte when read. Every host write lands in a one-byte input holding register, tagged as data or command. A sequencer drains that register through a take strobe.

Bytes bound for the host come from the serial receiver or from the command sequencer. Each one is offered with a load request, a keyboard/auxiliary tag and two error flags. The block accepts a byte only while its output holding register is empty. A producer that is refused must keep its request up until the register empties.

The block also holds the controller configuration byte, which the sequencer writes. It drives the keyboard and auxiliary interrupt requests from the buffer state and from the enable bits of that byte. Executing commands, serial timing and scancode translation are left to the neighbouring blocks.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset the output buffer is empty (`obReady`=1), the input buffer is empty (`inFull`=0), both interrupts are 0, `cfgByte` is 0x00, and the status byte equals `{3'b000, kbdUnlocked, 4'b0000}`.
- R2: A host write to the data location (`hostAddrCmd`=0) sets input-full (status bit 1) one cycle later, presents the byte on `inByte`, and makes `inIsCmd` and status bit 3 both 0.
- R3: A host write to the command location (`hostAddrCmd`=1) sets status bit 3 and `inIsCmd` to 1. Bit 3 keeps the tag of the last write even after the byte is taken.
- R4: `seqTake` clears input-full on the next cycle. When a host write falls in the same cycle as `seqTake`, the write wins: the buffer stays full and holds the new byte.
- R5: A host write while the input buffer is full replaces the held byte and its tag, and input-full stays 1.
- R6: `obLoad` while the output buffer is empty stores `obData`. On the next cycle status bit 0 is 1, `obReady` is 0, and status bits 5, 6 and 7 show the auxiliary tag, the timeout flag and the parity flag of that byte. A read of the data location returns the stored byte.
- R7: `obLoad` while the output buffer is full has no effect: the stored byte, its tag and its flags are unchanged.
- R8: A host read of the data location while the buffer is full clears output-full on the next cycle. A read of the command location returns the status byte and leaves output-full unchanged.
- R9: `irqKbd` is 1 exactly while the output buffer is full with keyboard data and configuration bit 0 is 1. `irqAux` is 1 exactly while it is full with auxiliary data and configuration bit 1 is 1.
- R10: `cfgWr` loads `cfgWrData` into the configuration byte with bit 7 forced to 0. Status bit 2 (the system flag) follows configuration bit 2.
- R11: Status bit 4 equals `kbdUnlocked` OR configuration bit 3, where `kbdUnlocked`=1 means not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddrCmd | input | 1 | 1 selects the command/status location, 0 the data location |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte: status or output buffer |
| inByte | output | 8 | Held input byte for the sequencer |
| inIsCmd | output | 1 | Held byte came from the command location |
| inFull | output | 1 | Input buffer holds an untaken byte |
| seqTake | input | 1 | Sequencer consumes the input byte |
| obLoad | input | 1 | Producer offers a byte for the host |
| obData | input | 8 | Offered byte |
| obAux | input | 1 | Offered byte is auxiliary-device data |
| obTimeout | input | 1 | Timeout flag for the offered byte |
| obParity | input | 1 | Parity error flag for the offered byte |
| obReady | output | 1 | Output buffer empty, an offer is accepted |
| cfgWr | input | 1 | Sequencer writes the configuration byte |
| cfgWrData | input | 8 | New configuration byte |
| cfgByte | output | 8 | Current configuration byte |
| kbdUnlocked | input | 1 | Keyboard lock input, 1 = not locked |
| irqKbd | output | 1 | Keyboard interrupt request |
| irqAux | output | 1 | Auxiliary interrupt request |

## Verification
The embedded properties watch the buffer flags on every cycle. They check that a write always leaves the input buffer full, that a take with no write empties it, and that a data-location read empties the output buffer. They also check that a refused offer never disturbs the stored byte and that an interrupt is only raised for a full buffer holding data of its own source. The exact status byte composition, the lock override, the value the host reads back, and the ordering between a refused offer and the later pop can only be shown by the bench's scenarios. The bench covers these through a scoreboard of expected read bytes.

// File: rtl/kbc_host_pkg.sv
package kbc_host_pkg;
  localparam int BYTE_W = 8;

  // status byte bit positions (host-visible layout)
  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_SYS  = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_LOCK = 4;
  localparam int ST_AUX  = 5;
  localparam int ST_TMO  = 6;
  localparam int ST_PAR  = 7;

  // configuration byte bit positions
  localparam int CF_KIRQ  = 0;
  localparam int CF_AIRQ  = 1;
  localparam int CF_SYS   = 2;
  localparam int CF_NOLCK = 3;
  localparam int CF_ZERO  = 7;

  typedef struct packed {
    logic ibLoad;   // capture host write byte
    logic obLoad;   // capture producer byte
  } strobes_t;

  typedef struct packed {
    logic obFull;
    logic ibFull;
    logic lastCmd;
  } flags_t;
endpackage

// File: rtl/kbc_host_ctrl.sv
module kbc_host_ctrl
  import kbc_host_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostWr,
  input  logic     hostRd,
  input  logic     hostAddrCmd,
  input  logic     seqTake,
  input  logic     obLoadReq,
  output strobes_t strb,
  output flags_t   flags
);
  logic obFullQ, ibFullQ, lastCmdQ;
  logic popData;

  assign popData     = hostRd && !hostAddrCmd;
  assign strb.ibLoad = hostWr;
  assign strb.obLoad = obLoadReq && !obFullQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obFullQ  <= 1'b0;
      ibFullQ  <= 1'b0;
      lastCmdQ <= 1'b0;
    end else begin
      if (hostWr) begin
        ibFullQ  <= 1'b1;
        lastCmdQ <= hostAddrCmd;
      end else if (seqTake) begin
        ibFullQ  <= 1'b0;
      end
      if (strb.obLoad)
        obFullQ <= 1'b1;
      else if (popData && obFullQ)
        obFullQ <= 1'b0;
    end
  end

  assign flags.obFull  = obFullQ;
  assign flags.ibFull  = ibFullQ;
  assign flags.lastCmd = lastCmdQ;

  // R2
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> ibFullQ);
  // R4
  take_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqTake && !hostWr) |=> !ibFullQ);
  // R3
  cmd_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddrCmd) |=> lastCmdQ);
  // R8
  pop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostAddrCmd && obFullQ) |=> !obFullQ);
  // R8
  status_read_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddrCmd && obFullQ) |=> obFullQ);
endmodule

// File: rtl/kbc_host_dp.sv
module kbc_host_dp
  import kbc_host_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobes_t     strb,
  input  flags_t       flags,
  input  logic         hostAddrCmd,
  input  logic [W-1:0] hostWrData,
  input  logic         obLoadReq,
  input  logic [W-1:0] obData,
  input  logic         obAux,
  input  logic         obTimeout,
  input  logic         obParity,
  input  logic         cfgWr,
  input  logic [W-1:0] cfgWrData,
  input  logic         kbdUnlocked,
  output logic [W-1:0] hostRdData,
  output logic [W-1:0] inByte,
  output logic [W-1:0] cfgByte,
  output logic         auxTag
);
  logic [W-1:0] ibReg, obReg, cfgReg, status;
  logic         auxQ, tmoQ, parQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibReg  <= '0;
      obReg  <= '0;
      cfgReg <= '0;
      auxQ   <= 1'b0;
      tmoQ   <= 1'b0;
      parQ   <= 1'b0;
    end else begin
      if (strb.ibLoad) ibReg <= hostWrData;
      if (strb.obLoad) begin
        obReg <= obData;
        auxQ  <= obAux;
        tmoQ  <= obTimeout;
        parQ  <= obParity;
      end
      if (cfgWr) begin
        cfgReg          <= cfgWrData;
        cfgReg[CF_ZERO] <= 1'b0;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_OBF]  = flags.obFull;
    status[ST_IBF]  = flags.ibFull;
    status[ST_SYS]  = cfgReg[CF_SYS];
    status[ST_CMD]  = flags.lastCmd;
    status[ST_LOCK] = kbdUnlocked | cfgReg[CF_NOLCK];
    status[ST_AUX]  = auxQ;
    status[ST_TMO]  = tmoQ;
    status[ST_PAR]  = parQ;
  end

  assign hostRdData = hostAddrCmd ? status : obReg;
  assign inByte     = ibReg;
  assign cfgByte    = cfgReg;
  assign auxTag     = auxQ;

  // R7
  refused_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags.obFull && obLoadReq) |=> ($stable(obReg) && $stable(auxQ)));
  // R6
  accepted_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flags.obFull && obLoadReq) |=> (obReg == $past(obData)));
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostAddrCmd,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic [7:0] inByte,
  output logic       inIsCmd,
  output logic       inFull,
  input  logic       seqTake,
  input  logic       obLoad,
  input  logic [7:0] obData,
  input  logic       obAux,
  input  logic       obTimeout,
  input  logic       obParity,
  output logic       obReady,
  input  logic       cfgWr,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgByte,
  input  logic       kbdUnlocked,
  output logic       irqKbd,
  output logic       irqAux
);
  strobes_t strb;
  flags_t   flags;
  logic     auxTag;

  kbc_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddrCmd(hostAddrCmd), .seqTake(seqTake), .obLoadReq(obLoad),
    .strb(strb), .flags(flags)
  );

  kbc_host_dp #(.W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flags(flags),
    .hostAddrCmd(hostAddrCmd), .hostWrData(hostWrData),
    .obLoadReq(obLoad), .obData(obData), .obAux(obAux),
    .obTimeout(obTimeout), .obParity(obParity),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .kbdUnlocked(kbdUnlocked),
    .hostRdData(hostRdData), .inByte(inByte), .cfgByte(cfgByte),
    .auxTag(auxTag)
  );

  assign inIsCmd = flags.lastCmd;
  assign inFull  = flags.ibFull;
  assign obReady = !flags.obFull;
  assign irqKbd  = flags.obFull && !auxTag && cfgByte[CF_KIRQ];
  assign irqAux  = flags.obFull &&  auxTag && cfgByte[CF_AIRQ];

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqKbd && irqAux));
  // R9
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    obReady |-> (!irqKbd && !irqAux));
endmodule

// File: tb/sim_kbc_host_regs.sv
module sim_kbc_host_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 0, hostRd = 0, hostAddrCmd = 0;
  logic [7:0] hostWrData = 0, hostRdData, inByte, cfgByte;
  logic inIsCmd, inFull, seqTake = 0, obLoad = 0, obAux = 0;
  logic obTimeout = 0, obParity = 0, obReady, cfgWr = 0, kbdUnlocked = 1;
  logic [7:0] obData = 0, cfgWrData = 0;
  logic irqKbd, irqAux;

  int vecs = 0, bad = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  always #5 clk = ~clk;

  kbc_host_regs u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: host read, expected value pushed to the scoreboard
  task automatic hostRead(input logic isCmd, input logic [7:0] exp, input string req);
    @(negedge clk);
    hostRd = 1; hostAddrCmd = isCmd;
    expQ.push_back(exp); tagQ.push_back(req);
    @(negedge clk);
    hostRd = 0;
  endtask

  // monitor: pops and compares while a read is on the bus
  always @(negedge clk) begin
    if (hostRd && expQ.size() > 0) begin
      #1;
      chk(tagQ.pop_front(), hostRdData, expQ.pop_front());
    end
  end

  task automatic hostWrite(input logic isCmd, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1; hostAddrCmd = isCmd; hostWrData = d;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic offer(input logic [7:0] d, input logic aux, input logic t, input logic p);
    @(negedge clk);
    obLoad = 1; obData = d; obAux = aux; obTimeout = t; obParity = p;
    @(negedge clk);
    obLoad = 0;
  endtask

  task automatic setCfg(input logic [7:0] d);
    @(negedge clk);
    cfgWr = 1; cfgWrData = d;
    @(negedge clk);
    cfgWr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk("R1 obReady", {7'b0, obReady}, 8'h01);
    chk("R1 inFull", {7'b0, inFull}, 8'h00);
    chk("R1 irq", {6'b0, irqKbd, irqAux}, 8'h00);
    chk("R1 cfg", cfgByte, 8'h00);
    hostRead(1, 8'h10, "R1 status");
    // R11 lock input and override
    kbdUnlocked = 0;
    hostRead(1, 8'h00, "R11 locked");
    setCfg(8'h08);
    hostRead(1, 8'h10, "R11 override");
    setCfg(8'h00);
    kbdUnlocked = 1;
    // R2 data write
    hostWrite(0, 8'hA5);
    chk("R2 inByte", inByte, 8'hA5);
    chk("R2 inIsCmd", {7'b0, inIsCmd}, 8'h00);
    hostRead(1, 8'h12, "R2 status");
    // R5 + R3 overwrite with a command
    hostWrite(1, 8'hAA);
    chk("R5 inByte", inByte, 8'hAA);
    chk("R3 inIsCmd", {7'b0, inIsCmd}, 8'h01);
    chk("R5 inFull", {7'b0, inFull}, 8'h01);
    // R4 take
    @(negedge clk); seqTake = 1;
    @(negedge clk); seqTake = 0;
    chk("R4 take", {7'b0, inFull}, 8'h00);
    hostRead(1, 8'h18, "R3 tag kept");
    // R4 take with simultaneous write
    @(negedge clk); seqTake = 1; hostWr = 1; hostAddrCmd = 0; hostWrData = 8'h3E;
    @(negedge clk); seqTake = 0; hostWr = 0;
    chk("R4 write wins", {7'b0, inFull}, 8'h01);
    chk("R4 new byte", inByte, 8'h3E);
    @(negedge clk); seqTake = 1;
    @(negedge clk); seqTake = 0;
    // R10 configuration
    setCfg(8'h85);
    chk("R10 cfg bit7", cfgByte, 8'h05);
    hostRead(1, 8'h14, "R10 sys flag");
    // R6 keyboard byte
    offer(8'h3C, 0, 0, 0);
    chk("R6 obReady", {7'b0, obReady}, 8'h00);
    chk("R9 irqKbd", {6'b0, irqKbd, irqAux}, 8'h02);
    hostRead(1, 8'h15, "R6 status");
    // R7 refused offer
    offer(8'h77, 1, 1, 1);
    hostRead(1, 8'h15, "R7 tags kept");
    hostRead(0, 8'h3C, "R7 byte kept");
    // R8 popped
    chk("R8 empty", {7'b0, obReady}, 8'h01);
    chk("R9 irq off", {6'b0, irqKbd, irqAux}, 8'h00);
    // R6 aux with errors, R9 gating
    offer(8'h5A, 1, 1, 1);
    chk("R9 aux gated", {6'b0, irqKbd, irqAux}, 8'h00);
    hostRead(1, 8'hF5, "R6 aux status");
    chk("R8 status read keeps", {7'b0, obReady}, 8'h00);
    setCfg(8'h02);
    chk("R9 irqAux", {6'b0, irqKbd, irqAux}, 8'h01);
    hostRead(0, 8'h5A, "R6 aux byte");
    chk("R8 aux popped", {7'b0, obReady}, 8'h01);
    chk("R9 aux irq off", {6'b0, irqKbd, irqAux}, 8'h00);
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    if (expQ.size() != 0) begin
      vecs++; bad++;
      $display("FAIL scoreboard actual=%0d expected=0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule